// File: doc/BRIEF.md
# Asynchronous serial receiver with status flags

This block takes an asynchronous serial line and rebuilds characters of 8 or 9 data bits from it. A baud tick input runs at sixteen times the bit rate. Each completed character is placed in a holding data register. A status register reports whether a character is waiting and whether noise, a framing error, an overrun or an idle line was seen. Software uses a small register port to pick the word length, turn the receiver on, and enable two interrupt sources. One source covers received characters and overrun. The other covers idle-line detection. A global mask input gates the shared interrupt output.

Software drains the receiver with a fixed two-step sequence. It first reads the status register, then reads the data register. Only that pair clears the flags. If a new character completes while the previous one has not been collected, the held character is kept. The newcomer stays in the shift register and the overrun flag is raised.

Register map (addr): 0 = status, read only: bit0 full, bit1 overrun, bit2 noise, bit3 framing error, bit4 idle. 1 = data, read only. 2 = control, read/write: bit0 enable, bit1 nine-bit mode, bit2 receive interrupt enable, bit3 idle interrupt enable, bit4 ninth data bit (read only). Address 3 reads zero.

Top module: `serial_rx_status`

## Requirements
- R1: After reset the status register (addr 0) and the control register (addr 2) read 0 and irq is low.
- R2: With control bit1 clear, a frame is received LSB first: one low start bit, 8 data bits, one high stop bit. After the stop bit, data (addr 1) holds the byte and status bit0 (full) is set.
- R3: With control bit1 set, 9 data bits are received. The low 8 go to the data register and the ninth appears as control bit4.
- R4: Each bit is decided by majority vote of oversamples 7, 8 and 9 of 16. If the three samples of any bit of a transferred character disagree, status bit2 (noise) is set.
- R5: A start bit whose vote reads high is discarded, and the receiver returns to hunting without producing a character.
- R6: A stop bit voted low sets status bit3 (framing error). An all-low break frame is therefore reported as a framing error with data 0x00.
- R7: A data read clears full, overrun, noise, framing and idle flags only when a status read came earlier and no data read came between them. A bare data read leaves the flags set.
- R8: If a character completes while full is set, status bit1 (overrun) is set. The data register keeps the older character, and a later character received after clearing is stored normally.
- R9: After a received character, status bit4 (idle) is set once the line has stayed high for one full character time (160 ticks in 8-bit mode, 176 in 9-bit mode). It is not set again until another character is received.
- R10: irq is high when (full or overrun) and control bit2 are set and mask_in is low.
- R11: irq is high when idle and control bit3 are set and mask_in is low.
- R12: While control bit0 is clear the receiver ignores the line and produces no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idles high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| mask_in | input | 1 | Global interrupt mask, high blocks irq |
| addr | input | 2 | Register select |
| rd_en | input | 1 | Read strobe (read side effects) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Clean frames in both word lengths separate correct bit ordering and placement of the ninth bit from shifted or truncated assembly. Frames with a single flipped sample in the start, a data or the stop bit show that the vote masks the glitch while the noise flag still records it. A low stop bit, an all-low break, a start pulse too short to survive the vote, and a second frame arriving before collection separate framing, false-start and overrun handling. An idle line measured to the exact tick, a bare data read, and the mask input separate the flag-clearing sequence and both interrupt sources.

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick16,
  input  logic       mask_in,
  input  logic [1:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(11 * OVS + 1);
  localparam int MID = OVS / 2;

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} st_t;

  st_t           st;
  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic [3:0]    bidx;
  logic [2:0]    vote;
  logic [8:0]    shf;
  logic          nz;
  logic [7:0]    dreg;
  logic          en, nine, rx_ie, idle_ie, r8;
  logic          full, ovr, noise, ferr, idle;
  logic          armed, idle_arm;
  logic [IW-1:0] icnt;

  wire [CW:0]   snum      = {1'b0, cnt} + 1'b1;
  wire          bit_end   = tick16 && (st != HUNT) && (snum == (CW+1)'(OVS));
  wire          maj       = (vote[0] & vote[1]) | (vote[0] & vote[2]) | (vote[1] & vote[2]);
  wire          dis       = |vote & ~&vote;
  wire          clr       = rd_en && addr == 2'd1 && armed;
  wire          eff_full  = full && !clr;
  wire [3:0]    nbits     = nine ? 4'd9 : 4'd8;
  wire [IW-1:0] fticks    = nine ? IW'(11 * OVS) : IW'(10 * OVS);
  wire          done      = (st == STOP) && bit_end;
  wire          idle_ev   = en && tick16 && st == HUNT && s2 && idle_arm && icnt == fticks - IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1;
      st <= HUNT; cnt <= '0; bidx <= '0; vote <= '0;
      shf <= '0; nz <= 1'b0; icnt <= '0;
    end else begin
      s1 <= rx_line;
      s2 <= s1;
      if (!en) begin
        st <= HUNT; cnt <= '0; icnt <= '0;
      end else if (tick16) begin
        if (st == HUNT) begin
          if (!s2) begin
            st <= START; cnt <= CW'(1); bidx <= '0; shf <= '0; icnt <= '0;
          end else if (idle_arm) begin
            icnt <= icnt + 1'b1;
          end
        end else begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (snum == (CW+1)'(MID - 1)) vote[0] <= s2;
          if (snum == (CW+1)'(MID))     vote[1] <= s2;
          if (snum == (CW+1)'(MID + 1)) vote[2] <= s2;
          if (bit_end) begin
            case (st)
              START: begin
                if (maj) st <= HUNT;
                else begin st <= DATA; nz <= dis; end
              end
              DATA: begin
                shf[bidx] <= maj;
                nz <= nz | dis;
                bidx <= bidx + 1'b1;
                if (bidx == nbits - 4'd1) st <= STOP;
              end
              default: st <= HUNT;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {full, ovr, noise, ferr, idle} <= '0;
      {idle_ie, rx_ie, nine, en} <= '0;
      dreg <= '0; r8 <= 1'b0; armed <= 1'b0; idle_arm <= 1'b0;
    end else begin
      if (rd_en && addr == 2'd0) armed <= 1'b1;
      else if (rd_en && addr == 2'd1) armed <= 1'b0;
      if (clr) {full, ovr, noise, ferr, idle} <= '0;
      if (done) begin
        idle_arm <= 1'b1;
        if (eff_full) ovr <= 1'b1;
        else begin
          full  <= 1'b1;
          dreg  <= shf[7:0];
          r8    <= nine & shf[8];
          noise <= nz | dis;
          ferr  <= !maj;
        end
      end
      if (idle_ev) begin
        idle <= 1'b1;
        idle_arm <= 1'b0;
      end
      if (wr_en && addr == 2'd2) {idle_ie, rx_ie, nine, en} <= wdata[3:0];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {3'b0, idle, ferr, noise, ovr, full};
      2'd1:    rdata = dreg;
      2'd2:    rdata = {3'b0, r8, idle_ie, rx_ie, nine, en};
      default: rdata = '0;
    endcase
  end

  assign irq = !mask_in && ((rx_ie && (full || ovr)) || (idle_ie && idle));

endmodule

module serial_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic       armed,
  input logic       full,
  input logic       ovr,
  input logic       idle,
  input logic       en,
  input logic       irq,
  input logic [1:0] st,
  input logic [7:0] dreg
);
  wire clr_c = rd_en && addr == 2'd1 && armed;

  p_clear_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(clr_c));

  p_ovr_with_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> full);

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(full) && !$past(clr_c)) |-> $stable(dreg));

  p_off_hunts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st == 2'd0);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (full || ovr || idle));
endmodule

bind serial_rx_status serial_rx_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .armed(armed),
  .full(full), .ovr(ovr), .idle(idle), .en(en), .irq(irq), .st(st), .dreg(dreg)
);

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b0, mask = 1'b0;
  logic [1:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int total = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_rx_status dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx), .tick16(tick), .mask_in(mask),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic       nine;
    logic [8:0] d;
    logic [3:0] fl;
    logic       stp;
    logic [4:0] est;
    logic [7:0] ed;
    logic       er8;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 9'h0A5, 4'hF, 1'b1, 5'b00001, 8'hA5, 1'b0},
    '{1'b0, 9'h03C, 4'h3, 1'b1, 5'b00101, 8'h3C, 1'b0},
    '{1'b1, 9'h1C3, 4'hF, 1'b1, 5'b00001, 8'hC3, 1'b1},
    '{1'b1, 9'h0FF, 4'h0, 1'b1, 5'b00101, 8'hFF, 1'b0},
    '{1'b0, 9'h05A, 4'hF, 1'b0, 5'b01001, 8'h5A, 1'b0},
    '{1'b1, 9'h100, 4'hA, 1'b1, 5'b00101, 8'h00, 1'b1}
  };

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic tk(input logic v);
    @(negedge clk) rx = v;
    @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input bit flip);
    for (int k = 1; k <= 16; k++) tk((k == 8 && flip) ? ~v : v);
  endtask

  task automatic send_frame(input logic nine, input logic [8:0] d, input int flip, input logic stp);
    int nb;
    nb = nine ? 9 : 8;
    send_bit(1'b0, flip == 0);
    for (int i = 0; i < nb; i++) send_bit(d[i], flip == i + 1);
    send_bit(stp, flip == nb + 1);
  endtask

  task automatic highs(input int n);
    for (int i = 0; i < n; i++) tk(1'b1);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk) begin addr = a; rd_en = 1'b1; end
    #1 v = rdata;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk) begin addr = a; wdata = d; wr_en = 1'b1; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int fl;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 control", v, 8'h00);
    chk("R1 irq", irq, 1'b0);
    rd(2'd1, v);

    send_frame(1'b0, 9'h0A5, -1, 1'b1); highs(4);
    rd(2'd0, v); chk("R12 disabled", v, 8'h00);
    rd(2'd1, v);

    for (int n = 0; n < 6; n++) begin
      wr(2'd2, {6'b0, VEC[n].nine, 1'b1});
      fl = (VEC[n].fl == 4'hF) ? -1 : int'(VEC[n].fl);
      send_frame(VEC[n].nine, VEC[n].d, fl, VEC[n].stp);
      highs(4);
      rd(2'd0, v);
      chk(VEC[n].fl != 4'hF ? "R4 status" : (!VEC[n].stp ? "R6 status" : "R2 status"), v, {3'b0, VEC[n].est});
      rd(2'd1, v);
      chk(VEC[n].nine ? "R3 data" : "R2 data", v, VEC[n].ed);
      rd(2'd2, v);
      chk("R3 ninth bit", v[4], VEC[n].er8);
      rd(2'd0, v);
      chk("R7 cleared", v, 8'h00);
      rd(2'd1, v);
    end

    wr(2'd2, 8'h01);
    send_frame(1'b0, 9'h011, -1, 1'b1); highs(4);
    rd(2'd1, v);
    rd(2'd0, v); chk("R7 bare data read", v, 8'h01);
    rd(2'd1, v); chk("R7 data", v, 8'h11);
    rd(2'd0, v); chk("R7 after sequence", v, 8'h00);
    rd(2'd1, v);

    wr(2'd2, 8'h05);
    send_frame(1'b0, 9'h022, -1, 1'b1); highs(4);
    chk("R10 irq", irq, 1'b1);
    mask = 1'b1; #1 chk("R10 masked", irq, 1'b0);
    mask = 1'b0;
    send_frame(1'b0, 9'h033, -1, 1'b1); highs(4);
    chk("R10 irq overrun", irq, 1'b1);
    rd(2'd0, v); chk("R8 overrun status", v, 8'h03);
    rd(2'd1, v); chk("R8 data kept", v, 8'h22);
    rd(2'd0, v); chk("R8 cleared", v, 8'h00);
    rd(2'd1, v);
    chk("R10 irq low", irq, 1'b0);
    send_frame(1'b0, 9'h044, -1, 1'b1); highs(4);
    rd(2'd0, v); chk("R8 next status", v, 8'h01);
    rd(2'd1, v); chk("R8 next data", v, 8'h44);

    send_frame(1'b0, 9'h000, -1, 1'b0); highs(4);
    rd(2'd0, v); chk("R6 break status", v, 8'h09);
    rd(2'd1, v); chk("R6 break data", v, 8'h00);

    for (int i = 0; i < 6; i++) tk(1'b0);
    highs(14);
    rd(2'd0, v); chk("R5 no char", v, 8'h00);
    rd(2'd1, v);
    send_frame(1'b0, 9'h096, -1, 1'b1); highs(4);
    rd(2'd0, v); chk("R5 next status", v, 8'h01);
    rd(2'd1, v); chk("R5 next data", v, 8'h96);

    wr(2'd2, 8'h09);
    send_frame(1'b0, 9'h001, -1, 1'b1);
    highs(159);
    rd(2'd0, v); chk("R9 idle early", v[4], 1'b0);
    chk("R11 irq early", irq, 1'b0);
    highs(1);
    rd(2'd0, v); chk("R9 idle set", v[4], 1'b1);
    chk("R11 irq", irq, 1'b1);
    mask = 1'b1; #1 chk("R11 masked", irq, 1'b0);
    mask = 1'b0;
    rd(2'd1, v);
    chk("R11 irq cleared", irq, 1'b0);
    highs(200);
    rd(2'd0, v); chk("R9 once only", v, 8'h00);
    rd(2'd1, v);

    finish_run();
  end
endmodule